// File: doc/BRIEF.md
# Five-Channel Timer Start and Compare-Output Control

The block holds five independent 16-bit up-counters, each paired with a compare register and one output pin. A single 8-bit start register decides which counters advance. Each channel also has a mode register, which holds the pin's output enable, and a 3-bit I/O control field. That field gives the pin's initial level and the action taken on a compare match. Software reaches every register through a single-cycle register bus: a write lands on the clock edge, and a read returns the addressed register combinationally in the same cycle.

When a channel is stopped, its counter freezes and its pin holds whatever level the compare logic last drove. It does not fall back to a default. While a channel is stopped, writing its I/O control field forces the pin level to the initial level carried in that write. While it runs, the same write changes only the compare action. The mode register can be changed only while the channel is stopped.

Top module: `tmr_start_ctrl`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0, every counter is 0, every pin is 0 and all channels are stopped.
- R2: The start register sits at address 0x00. Bit 7 runs channel 4, bit 6 runs channel 3, and bits 2, 1 and 0 run channels 2, 1 and 0. A start register write takes effect on its own write edge, so a channel started by a write already counts on that edge, and a channel stopped by a write no longer counts on it.
- R3: Bits 5 to 3 of the start register always read 0, and writing 1 to them starts nothing.
- R4: A channel's counter adds 1 on every edge on which it runs, holds its value on every edge on which it is stopped, and wraps from 0xFFFF to 0x0000. A counter byte write replaces that byte and takes priority over counting in that cycle.
- R5: When a running channel's counter equals its compare value before an edge, that edge applies the action in I/O control bits 1:0 to the pin level: 00 keeps it, 01 drives 0, 10 drives 1, 11 inverts it. The pin shows this level when mode bit 0 (output enable) is 1, and shows 0 when that bit is 0.
- R6: Stopping a channel leaves its pin level unchanged for as long as it stays stopped.
- R7: An I/O control write to a stopped channel sets the pin level to bit 2 of the written value, effective from the write edge.
- R8: An I/O control write to a running channel updates the stored field and the compare action, and does not change the pin level.
- R9: A mode register write takes effect only while the channel is stopped. It is ignored while the channel runs. Only bit 0 is kept, and the other bits read 0.
- R10: Channel c (0 to 4) occupies addresses 0x10·(c+1) plus an offset: 0 mode, 1 I/O control (bits 2:0), 2 and 3 compare low and high byte, 4 and 5 counter low and high byte. Any other address reads 0, and all reads return data in the cycle the read enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write enable |
| bus_re | input | 1 | Register read enable |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_re |
| cmp_pin | output | 5 | Compare output pin of each channel |

## Verification
A write, and the pin level it affects, becomes visible one edge after the write is driven. A counter started by a write shows 1 right after that write edge and gains one per edge after that. A compare action appears on the pin right after the edge on which the pre-edge count equals the compare value. Reads are combinational, so the bench drives every input at the falling edge, queues the expected value, and compares it one nanosecond later in the same cycle. Each expected count is derived by numbering the edges from the start write, so the value is sampled in exactly the cycle it is due.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int N_CH       = 5;
    localparam int CNT_W      = 16;
    localparam int BUS_AW     = 8;
    localparam int BUS_DW     = 8;
    localparam int CNT_BYTES  = CNT_W / 8;
    localparam int IOC_W      = 3;

    localparam logic [BUS_AW-1:0] START_ADDR = 8'h00;
    localparam logic [3:0]        SEL_MODE   = 4'h0;
    localparam logic [3:0]        SEL_IOC    = 4'h1;
    localparam int                SEL_CMP0   = 2;
    localparam int                SEL_CNT0   = SEL_CMP0 + CNT_BYTES;

    typedef enum logic [1:0] {
        ACT_KEEP   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_INVERT = 2'b11
    } cmp_act_e;

    typedef struct packed {
        logic     init_lvl;
        cmp_act_e act;
    } io_cfg_t;

    typedef struct packed {
        logic                  mode_we;
        logic                  ioc_we;
        logic [CNT_BYTES-1:0]  cmp_we;
        logic [CNT_BYTES-1:0]  cnt_we;
        logic [BUS_DW-1:0]     data;
    } chan_wr_t;

    typedef struct packed {
        logic              oe;
        io_cfg_t           ioc;
        logic [CNT_W-1:0]  cmp;
        logic [CNT_W-1:0]  cnt;
    } chan_rd_t;

    // bit of the start register that runs channel ch
    function automatic int start_bit(input int ch);
        return (ch < 3) ? ch : ch + 3;
    endfunction

    function automatic logic [BUS_DW-1:0] start_mask();
        logic [BUS_DW-1:0] m;
        m = '0;
        for (int ch = 0; ch < N_CH; ch++) begin
            m[start_bit(ch)] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic next_level(input cmp_act_e act, input logic cur);
        case (act)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_INVERT: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/tsc_regfile.sv
module tsc_regfile
    import tsc_pkg::*;
#(
    parameter int NCH = N_CH
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_we,
    input  logic                    bus_re,
    input  logic [BUS_AW-1:0]       bus_addr,
    input  logic [BUS_DW-1:0]       bus_wdata,
    output logic [BUS_DW-1:0]       bus_rdata,
    input  chan_rd_t [NCH-1:0]      ch_rd,
    output chan_wr_t [NCH-1:0]      ch_wr,
    output logic [NCH-1:0]          ch_run
);

    localparam logic [BUS_DW-1:0] VALID = start_mask();

    logic [BUS_DW-1:0] start_q;
    logic              start_we;
    logic [3:0]        sel;

    assign start_we = bus_we && (bus_addr == START_ADDR);
    assign sel      = bus_addr[3:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (start_we) begin
            start_q <= bus_wdata & VALID;
        end
    end

    // a start write acts on its own edge
    for (genvar c = 0; c < NCH; c++) begin : g_run
        localparam int SB = start_bit(c);
        assign ch_run[c] = start_we ? bus_wdata[SB] : start_q[SB];
    end

    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            logic hit;
            hit = bus_we && (bus_addr[7:4] == 4'(c + 1));
            ch_wr[c].mode_we = hit && (sel == SEL_MODE);
            ch_wr[c].ioc_we  = hit && (sel == SEL_IOC);
            for (int b = 0; b < CNT_BYTES; b++) begin
                ch_wr[c].cmp_we[b] = hit && (sel == 4'(SEL_CMP0 + b));
                ch_wr[c].cnt_we[b] = hit && (sel == 4'(SEL_CNT0 + b));
            end
            ch_wr[c].data = bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_re) begin
            if (bus_addr == START_ADDR) begin
                bus_rdata = start_q;
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    if (bus_addr[7:4] == 4'(c + 1)) begin
                        if (sel == SEL_MODE) bus_rdata = {{(BUS_DW-1){1'b0}}, ch_rd[c].oe};
                        if (sel == SEL_IOC)  bus_rdata = {{(BUS_DW-IOC_W){1'b0}}, ch_rd[c].ioc};
                        for (int b = 0; b < CNT_BYTES; b++) begin
                            if (sel == 4'(SEL_CMP0 + b)) bus_rdata = ch_rd[c].cmp[8*b +: 8];
                            if (sel == 4'(SEL_CNT0 + b)) bus_rdata = ch_rd[c].cnt[8*b +: 8];
                        end
                    end
                end
            end
        end
    end

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_re && bus_addr == START_ADDR) |-> ((bus_rdata & ~VALID) == '0)); // R3

    AST_START_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start_we |=> $stable(start_q)); // R2

endmodule

// File: rtl/tsc_counter.sv
module tsc_counter
    import tsc_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int NB = W / 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [NB-1:0]   load_we,
    input  logic [7:0]      load_data,
    input  logic [W-1:0]    cmp,
    output logic [W-1:0]    cnt,
    output logic            match
);

    logic [W-1:0] cnt_nxt;

    assign match = run && (cnt == cmp);

    always_comb begin
        cnt_nxt = cnt;
        if (|load_we) begin
            for (int b = 0; b < NB; b++) begin
                if (load_we[b]) cnt_nxt[8*b +: 8] = load_data;
            end
        end else if (run) begin
            cnt_nxt = cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (!run && load_we == '0) |=> $stable(cnt)); // R4

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (run && load_we == '0) |=> (cnt == W'($past(cnt) + 1'b1))); // R4

endmodule

// File: rtl/tsc_pin_out.sv
module tsc_pin_out
    import tsc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              mode_we,
    input  logic              ioc_we,
    input  logic [IOC_W-1:0]  wdata,
    input  logic              match,
    output logic              oe,
    output io_cfg_t           ioc,
    output logic              pin
);

    logic level;

    always_ff @(posedge clk) begin
        if (rst) begin
            oe    <= 1'b0;
            ioc   <= '0;
            level <= 1'b0;
        end else begin
            if (mode_we && !run) oe <= wdata[0];
            if (ioc_we) ioc <= io_cfg_t'(wdata);
            if (ioc_we && !run) begin
                level <= wdata[2];
            end else if (match) begin
                level <= next_level(ioc.act, level);
            end
        end
    end

    assign pin = oe & level;

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!run && !ioc_we) |=> $stable(level)); // R6

    AST_INIT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (ioc_we && !run) |=> (level == $past(wdata[2]))); // R7

    AST_RUN_IOC_NOPIN: assert property (@(posedge clk) disable iff (rst)
        (ioc_we && run && !match) |=> $stable(level)); // R8

    AST_MODE_LOCK: assert property (@(posedge clk) disable iff (rst)
        (mode_we && run) |=> $stable(oe)); // R9

endmodule

// File: rtl/tsc_channel.sv
module tsc_channel
    import tsc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  chan_wr_t  wr,
    output chan_rd_t  rd,
    output logic      pin
);

    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt;
    logic             match;
    logic             oe;
    io_cfg_t          ioc;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '0;
        end else begin
            for (int b = 0; b < CNT_BYTES; b++) begin
                if (wr.cmp_we[b]) cmp_q[8*b +: 8] <= wr.data;
            end
        end
    end

    tsc_counter #(.W(CNT_W)) i_counter (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .load_we   (wr.cnt_we),
        .load_data (wr.data),
        .cmp       (cmp_q),
        .cnt       (cnt),
        .match     (match)
    );

    tsc_pin_out i_pin (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .mode_we (wr.mode_we),
        .ioc_we  (wr.ioc_we),
        .wdata   (wr.data[IOC_W-1:0]),
        .match   (match),
        .oe      (oe),
        .ioc     (ioc),
        .pin     (pin)
    );

    assign rd.oe  = oe;
    assign rd.ioc = ioc;
    assign rd.cmp = cmp_q;
    assign rd.cnt = cnt;

endmodule

// File: rtl/tmr_start_ctrl.sv
module tmr_start_ctrl
    import tsc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_we,
    input  logic               bus_re,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [BUS_DW-1:0]  bus_wdata,
    output logic [BUS_DW-1:0]  bus_rdata,
    output logic [N_CH-1:0]    cmp_pin
);

    chan_wr_t [N_CH-1:0] ch_wr;
    chan_rd_t [N_CH-1:0] ch_rd;
    logic     [N_CH-1:0] ch_run;

    tsc_regfile #(.NCH(N_CH)) i_regfile (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_rd     (ch_rd),
        .ch_wr     (ch_wr),
        .ch_run    (ch_run)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        tsc_channel i_channel (
            .clk (clk),
            .rst (rst),
            .run (ch_run[c]),
            .wr  (ch_wr[c]),
            .rd  (ch_rd[c]),
            .pin (cmp_pin[c])
        );
    end

endmodule

// File: tb/test_tmr_start_ctrl.sv
module test_tmr_start_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [4:0] cmp_pin;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        bit         is_pin;
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    tmr_start_ctrl i_tmr_start_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmp_pin   (cmp_pin)
    );

    function automatic logic [7:0] ra(input int ch, input int off);
        return 8'((ch + 1) * 16 + off);
    endfunction

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_re = 1'b0; bus_addr = a; bus_wdata = d;
    endtask

    task automatic bus_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_we = 1'b0; bus_re = 1'b0;
        end
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_we = 1'b0; bus_re = 1'b1; bus_addr = a;
        it.is_pin = 0; it.sel = int'(a); it.exp = e; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic chk_pin(input int ch, input logic e, input string tag);
        item_t it;
        it.is_pin = 1; it.sel = ch; it.exp = {7'b0, e}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compares queued expectations 1 ns after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it = sb_q.pop_front();
                act = it.is_pin ? {7'b0, cmp_pin[it.sel]} : bus_rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s %s %0h actual %0h expected %0h", it.tag,
                             it.is_pin ? "pin" : "addr", it.sel, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_rd(8'h00, 8'h00, "R1");
        for (int c = 0; c < 5; c++) chk_pin(c, 1'b0, "R1");
        chk_rd(ra(0, 4), 8'h00, "R1");

        // R3 reserved bits
        bus_wr(8'h00, 8'h38);
        chk_rd(8'h00, 8'h00, "R3");
        chk_rd(ra(0, 4), 8'h00, "R3");

        // R9 mode accepted while stopped
        for (int c = 0; c < 5; c++) bus_wr(ra(c, 0), 8'hFF);
        chk_rd(ra(0, 0), 8'h01, "R9");

        // R7 initial level while stopped
        bus_wr(ra(0, 1), 8'h04);
        bus_idle(1);
        chk_pin(0, 1'b1, "R7");
        bus_wr(ra(0, 1), 8'h03);
        bus_idle(1);
        chk_pin(0, 1'b0, "R7");
        chk_rd(ra(0, 1), 8'h03, "R10");

        // R5 toggle on compare, R4 counting
        bus_wr(ra(0, 2), 8'h05);
        bus_wr(ra(0, 3), 8'h00);
        chk_rd(ra(0, 2), 8'h05, "R10");
        bus_wr(8'h00, 8'h01);
        bus_idle(5);
        chk_pin(0, 1'b0, "R5");
        bus_idle(1);
        chk_pin(0, 1'b1, "R5");
        chk_rd(ra(0, 4), 8'h07, "R4");

        // R6 stop holds level, R4 frozen
        bus_wr(8'h00, 8'h00);
        bus_idle(3);
        chk_pin(0, 1'b1, "R6");
        chk_rd(ra(0, 4), 8'h08, "R4");
        bus_wr(ra(0, 1), 8'h00);
        bus_idle(1);
        chk_pin(0, 1'b0, "R7");

        // R8 I/O control write while running
        bus_wr(ra(1, 2), 8'h03);
        bus_wr(ra(1, 1), 8'h02);
        bus_idle(1);
        chk_pin(1, 1'b0, "R7");
        bus_wr(8'h00, 8'h02);
        bus_wr(ra(1, 1), 8'h05);
        bus_idle(1);
        chk_pin(1, 1'b0, "R8");
        bus_idle(2);
        chk_pin(1, 1'b0, "R8");
        chk_rd(ra(1, 1), 8'h05, "R8");

        // R9 mode write ignored while running
        bus_wr(ra(1, 0), 8'h00);
        chk_rd(ra(1, 0), 8'h01, "R9");
        bus_wr(8'h00, 8'h00);

        // R2 bit mapping for channels 3 and 4, R5 drive actions
        bus_wr(ra(3, 2), 8'h02);
        bus_wr(ra(3, 1), 8'h02);
        bus_wr(ra(4, 2), 8'h01);
        bus_wr(ra(4, 1), 8'h05);
        bus_idle(1);
        chk_pin(3, 1'b0, "R7");
        chk_pin(4, 1'b1, "R7");
        bus_wr(8'h00, 8'hC0);
        chk_rd(ra(3, 4), 8'h01, "R2");
        chk_pin(3, 1'b0, "R5");
        chk_pin(4, 1'b1, "R5");
        chk_rd(ra(4, 4), 8'h02, "R2");
        chk_pin(4, 1'b0, "R5");
        chk_rd(ra(2, 4), 8'h00, "R2");
        chk_pin(3, 1'b1, "R5");
        chk_rd(8'h00, 8'hC0, "R2");
        bus_wr(8'h00, 8'h00);

        // R5 output enable masking
        bus_wr(ra(4, 0), 8'h00);
        bus_wr(ra(4, 1), 8'h04);
        bus_idle(1);
        chk_pin(4, 1'b0, "R5");
        bus_wr(ra(4, 0), 8'h01);
        bus_idle(1);
        chk_pin(4, 1'b1, "R5");

        // R4 wrap
        bus_wr(ra(2, 4), 8'hFF);
        bus_wr(ra(2, 5), 8'hFF);
        chk_rd(ra(2, 5), 8'hFF, "R4");
        bus_wr(8'h00, 8'h04);
        chk_rd(ra(2, 5), 8'h00, "R4");
        chk_rd(ra(2, 4), 8'h01, "R4");

        // R10 unmapped address
        chk_rd(8'h0F, 8'h00, "R10");
        bus_idle(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule